// File: doc/BRIEF.md
# Configurable Byte Frame Serializer

This block turns a stream of transmit bytes into a single NRZ bit stream for a contactless link. Each byte is wrapped in a frame chosen by a set of configuration inputs. The frame can have a leading start bit of logic 0. The eight data bits can go out in either order. A per-byte parity bit can be even or odd, and the parity of the final byte can be complemented. The frame ends with a trailer of stop and guard bits, all at logic 1. The block emits plain bits only. Line codes, modulation and CRC are handled by other logic.

A transfer begins with a one-cycle start strobe. On that strobe the block takes a snapshot of the configuration and of the byte count. Bytes then arrive over a valid/ready handshake. The frame ends when the counted number of bytes has been taken, or earlier if a byte is flagged as the last one. Bits move only on a single-cycle bit-clock enable, so the bit rate is set outside the block.

When nothing is being sent the line rests at logic 1. A start with a byte count of zero sends nothing and raises a sticky error flag.

Top module: `ftx_frame_serializer`

## Requirements
- R1: With the start-bit enable set, every byte's frame begins with one bit of value 0. With it clear, no start bit is sent.
- R2: With msb-first set, the data bits go out bit 7 down to bit 0. With it clear, they go out bit 0 up to bit 7.
- R3: With parity enabled, one parity bit follows the eight data bits. A parity-type input of 0 makes the count of ones over data plus parity even. A value of 1 makes that count odd. With parity disabled, no parity bit is sent.
- R4: With last-parity-invert set, the parity bit of the final byte of the transfer is complemented. The parity bits of all earlier bytes keep their normal value.
- R5: The 3-bit trailer field N sets the trailer length. N=0 sends no trailer. N=1 sends one stop bit. N from 2 to 7 sends one stop bit plus N-1 guard bits. Every trailer bit is 1.
- R6: A start strobe while idle with a byte count of 0 sets err_no_data in the next cycle. Busy stays low and no bit is sent. The flag stays set until the next accepted start strobe, which clears it when that strobe's byte count is nonzero.
- R7: A transfer ends after byte_count bytes have been taken, or with the first byte that carries in_last, whichever comes first. No further byte is taken. That ending byte is the one treated as final for R4.
- R8: tx_bit and bit_strobe change only at clock edges where bit_en is high. bit_strobe is high for exactly one cycle after each frame bit is placed on tx_bit.
- R9: tx_bit is 1 whenever no frame bit is being driven. This covers idle, and also a bit_en edge at which no byte is ready.
- R10: busy rises in the cycle after an accepted start strobe. It falls at the first bit_en edge after the last trailer bit was placed. The configuration and byte count are sampled at the strobe. A start strobe or a configuration change during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Single-cycle bit-clock enable |
| start | input | 1 | Start strobe for one transfer |
| cfg_stop | input | 3 | Trailer field: stop bit and guard-bit count |
| cfg_start_bit | input | 1 | Send a 0 start bit before each byte |
| cfg_msb_first | input | 1 | Send data bits MSB first |
| cfg_par_en | input | 1 | Append a parity bit to each byte |
| cfg_par_odd | input | 1 | Parity type: 0 even, 1 odd |
| cfg_par_inv_last | input | 1 | Complement the parity of the final byte |
| byte_count | input | CNT_W | Number of bytes in the transfer |
| in_data | input | 8 | Transmit byte |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | Current byte is the final one |
| in_ready | output | 1 | Block takes in_data at this edge when valid |
| tx_bit | output | 1 | Serial NRZ output line |
| bit_strobe | output | 1 | A frame bit was placed on tx_bit |
| busy | output | 1 | Transfer in progress |
| err_no_data | output | 1 | Sticky no-data error |

## Verification
The bench sweeps every combination of start bit, bit order, parity enable, parity type, final-byte inversion and all eight trailer codes over two-byte transfers. It compares the captured stream with one rebuilt arithmetically. A design that inverted every parity bit instead of only the final one, sent the trailer one guard bit short, or reversed the bit-order decode shows up as a stream mismatch.

Early termination through in_last is checked by counting the bytes actually taken. Stalled input must leave idle-high gaps without strobes. A start strobe and a configuration change in the middle of a transfer must not alter its bits.

The timing of the falling busy edge is measured against the last strobe, so a design that drops busy one bit period early or late is caught. The zero-count start must leave the line silent with a sticky error that a later start clears.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int BYTE_W    = 8;
  localparam int STOP_W    = 3;
  localparam int GUARD_MAX = (1 << STOP_W) - 2;
  localparam int FRAME_W   = 1 + BYTE_W + 1 + 1 + GUARD_MAX;
  localparam int LEN_W     = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [STOP_W-1:0] stop;
    logic              start_bit;
    logic              msb_first;
    logic              par_en;
    logic              par_odd;
    logic              par_inv_last;
  } ftx_cfg_t;

  // parity bit for a byte: even base, flipped for odd type and for final-byte inversion
  function automatic logic ftx_parity_bit(input logic [BYTE_W-1:0] d,
                                          input logic odd, input logic flip);
    return (^d) ^ odd ^ flip;
  endfunction

  // data bits arranged so that index 0 is the first bit on the line
  function automatic logic [BYTE_W-1:0] ftx_order(input logic [BYTE_W-1:0] d,
                                                  input logic msb_first);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
    return msb_first ? r : d;
  endfunction

  // trailer length equals the field value: stop bit plus (value-1) guard bits
  function automatic logic [LEN_W-1:0] ftx_frame_len(input ftx_cfg_t c);
    int n;
    n = BYTE_W + int'(c.start_bit) + int'(c.par_en) + int'(c.stop);
    return LEN_W'(n);
  endfunction
endpackage

// File: rtl/ftx_byte_framer.sv
module ftx_byte_framer
  import ftx_pkg::*;
(
  input  ftx_cfg_t           cfg,
  input  logic [BYTE_W-1:0]  data,
  input  logic               is_last,
  output logic [FRAME_W-1:0] bits,
  output logic [LEN_W-1:0]   len
);
  logic [BYTE_W-1:0] ordered;
  logic              par;

  assign ordered = ftx_order(data, cfg.msb_first);
  assign par     = ftx_parity_bit(data, cfg.par_odd, cfg.par_inv_last & is_last);
  assign len     = ftx_frame_len(cfg);

  // unused upper positions and the trailer stay at 1
  always_comb begin
    bits = '1;
    if (cfg.start_bit) begin
      bits[0]        = 1'b0;
      bits[BYTE_W:1] = ordered;
      if (cfg.par_en) bits[BYTE_W+1] = par;
    end else begin
      bits[BYTE_W-1:0] = ordered;
      if (cfg.par_en) bits[BYTE_W] = par;
    end
  end
endmodule

// File: rtl/ftx_bit_shifter.sv
module ftx_bit_shifter
  import ftx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_bits,
  input  logic [LEN_W-1:0]   load_len,
  output logic               tx_bit,
  output logic               bit_strobe,
  output logic               empty
);
  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   left_q;
  logic               emit;

  assign empty = (left_q == '0);
  assign emit  = bit_en && !load && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '1;
      left_q     <= '0;
      tx_bit     <= 1'b1;
      bit_strobe <= 1'b0;
    end else begin
      bit_strobe <= emit;
      if (load) begin
        sr_q   <= load_bits;
        left_q <= load_len;
      end else if (emit) begin
        sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
        left_q <= left_q - LEN_W'(1);
      end
      if (bit_en) tx_bit <= emit ? sr_q[0] : 1'b1;
    end
  end

  a_r8_quiet_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (!bit_strobe && $stable(tx_bit)));
  a_r8_load_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty);
endmodule

// File: rtl/ftx_frame_ctrl.sv
module ftx_frame_ctrl
  import ftx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  ftx_cfg_t         cfg_in,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             bit_en,
  input  logic             sh_empty,
  output ftx_cfg_t         cfg_q,
  output logic             in_ready,
  output logic             byte_take,
  output logic             take_last,
  output logic             busy,
  output logic             err_no_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_FEED, ST_TAIL} ftx_state_t;

  ftx_state_t       state_q;
  logic [CNT_W-1:0] left_q;
  logic             start_ok;
  logic             start_empty;
  logic             frame_done;

  assign start_ok    = start && (state_q == ST_IDLE);
  assign start_empty = start_ok && (byte_count == '0);
  assign in_ready    = (state_q == ST_FEED) && sh_empty;
  assign byte_take   = in_ready && in_valid;
  assign take_last   = in_last || (left_q == CNT_W'(1));
  assign frame_done  = (state_q == ST_TAIL) && sh_empty && bit_en;
  assign busy        = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      left_q      <= '0;
      cfg_q       <= '0;
      err_no_data <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          err_no_data <= start_empty;
          if (!start_empty) begin
            cfg_q   <= cfg_in;
            left_q  <= byte_count;
            state_q <= ST_FEED;
          end
        end
        ST_FEED: if (byte_take) begin
          left_q <= left_q - CNT_W'(1);
          if (take_last) state_q <= ST_TAIL;
        end
        ST_TAIL: if (frame_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_empty_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
    start_empty |=> (err_no_data && !busy));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_no_data && !start_ok) |=> err_no_data);
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));
  a_r7_take_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> (left_q != '0));
endmodule

// File: rtl/ftx_frame_serializer.sv
module ftx_frame_serializer
  import ftx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              start,
  input  logic [STOP_W-1:0] cfg_stop,
  input  logic              cfg_start_bit,
  input  logic              cfg_msb_first,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_par_inv_last,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              bit_strobe,
  output logic              busy,
  output logic              err_no_data
);
  ftx_cfg_t           cfg_in;
  ftx_cfg_t           cfg_q;
  logic               byte_take;
  logic               take_last;
  logic               sh_empty;
  logic [FRAME_W-1:0] frame_bits;
  logic [LEN_W-1:0]   frame_len;

  always_comb begin
    cfg_in.stop         = cfg_stop;
    cfg_in.start_bit    = cfg_start_bit;
    cfg_in.msb_first    = cfg_msb_first;
    cfg_in.par_en       = cfg_par_en;
    cfg_in.par_odd      = cfg_par_odd;
    cfg_in.par_inv_last = cfg_par_inv_last;
  end

  ftx_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
    .byte_count(byte_count), .in_valid(in_valid), .in_last(in_last),
    .bit_en(bit_en), .sh_empty(sh_empty), .cfg_q(cfg_q),
    .in_ready(in_ready), .byte_take(byte_take), .take_last(take_last),
    .busy(busy), .err_no_data(err_no_data)
  );

  ftx_byte_framer u_framer (
    .cfg(cfg_q), .data(in_data), .is_last(take_last),
    .bits(frame_bits), .len(frame_len)
  );

  ftx_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(byte_take),
    .load_bits(frame_bits), .load_len(frame_len),
    .tx_bit(tx_bit), .bit_strobe(bit_strobe), .empty(sh_empty)
  );

  a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_bit);
  a_r10_no_strobe_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bit_strobe);
endmodule

// File: tb/tb_ftx_frame_serializer.sv
module tb_ftx_frame_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int BITP       = 3;
  localparam int CNT_W      = 8;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, start = 1'b0;
  logic [2:0] cfg_stop = '0;
  logic cfg_start_bit = 0, cfg_msb_first = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_par_inv_last = 0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 0, in_last = 0;
  logic in_ready, tx_bit, bit_strobe, busy, err_no_data;

  ftx_frame_serializer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
    .cfg_stop(cfg_stop), .cfg_start_bit(cfg_start_bit), .cfg_msb_first(cfg_msb_first),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_par_inv_last(cfg_par_inv_last),
    .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit), .bit_strobe(bit_strobe), .busy(busy),
    .err_no_data(err_no_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_err = 0;
  logic [7:0] fb [0:7];
  logic       fl [0:7];
  int n_feed = 8, feed_idx = 0, tick = 0, cyc = 0;
  int idle_bad = 0, en_bad = 0;
  logic hs = 1'b0, stall_en = 1'b0, prev_tx = 1'b1;
  logic cap [$];
  logic exp_q [$];
  time last_strobe_t = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  always @(posedge clk) hs <= in_valid && in_ready;

  always @(negedge clk) begin
    cyc++;
    if (bit_strobe) begin cap.push_back(tx_bit); last_strobe_t = $time; end
    if (rst_n) begin
      if (!busy && !tx_bit) idle_bad++;                 // R9
      if (bit_en && !bit_strobe && !tx_bit) idle_bad++; // R9 gap
      if (!bit_en && bit_strobe) en_bad++;              // R8
      if (!bit_en && tx_bit !== prev_tx) en_bad++;      // R8
    end
    prev_tx = tx_bit;
    if (hs) feed_idx++;
    in_valid = (feed_idx < n_feed) && !(stall_en && (cyc % 11) < 7);
    in_data  = fb[feed_idx < 8 ? feed_idx : 0];
    in_last  = fl[feed_idx < 8 ? feed_idx : 0];
    tick   = (tick + 1) % BITP;
    bit_en = (tick == 0);
  end

  task automatic build_expected(input int nb);
    exp_q.delete();
    for (int b = 0; b < nb; b++) begin
      int ones;
      logic p;
      ones = 0;
      if (cfg_start_bit) exp_q.push_back(1'b0);
      for (int i = 0; i < 8; i++) exp_q.push_back(fb[b][cfg_msb_first ? 7 - i : i]);
      for (int i = 0; i < 8; i++) ones += int'(fb[b][i]);
      if (cfg_par_en) begin
        p = (ones % 2) == 1;
        if (cfg_par_odd) p = !p;
        if (cfg_par_inv_last && b == nb - 1) p = !p;
        exp_q.push_back(p);
      end
      for (int s = 0; s < int'(cfg_stop); s++) exp_q.push_back(1'b1);
    end
  endtask

  task automatic run_frame(input int cnt, input bit stall, input bit poke, input string tag);
    int nb, bad;
    nb = cnt;
    for (int i = 0; i < cnt; i++) if (fl[i]) begin nb = i + 1; break; end
    build_expected(nb);
    @(negedge clk);
    cap.delete(); feed_idx = 0; stall_en = stall; byte_count = CNT_W'(cnt);
    idle_bad = 0; en_bad = 0;
    @(negedge clk); @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy in cycle after start", int'(busy), 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1'b1; cfg_msb_first = !cfg_msb_first; cfg_stop = cfg_stop ^ 3'd5;
      cfg_par_odd = !cfg_par_odd;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(($time - last_strobe_t) == BITP * CLK_PERIOD, "R10",
          "busy fall delay after last bit (ns)", int'($time - last_strobe_t), BITP * CLK_PERIOD);
    check(cap.size() == exp_q.size(), tag, "frame bit count", cap.size(), exp_q.size());
    bad = 0;
    for (int i = 0; i < exp_q.size() && i < cap.size(); i++) if (cap[i] !== exp_q[i]) bad++;
    check(bad == 0, tag, "mismatched frame bits", bad, 0);
    check(feed_idx == nb, "R7", "bytes taken", feed_idx, nb);
    check(idle_bad == 0, "R9", "line low while not sending", idle_bad, 0);
    check(en_bad == 0, "R8", "output change without bit_en", en_bad, 0);
    stall_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin fb[i] = 8'(i * 53 + 17); fl[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(tx_bit == 1'b1, "R9", "line after reset", int'(tx_bit), 1);
    check(err_no_data == 1'b0, "R6", "error after reset", int'(err_no_data), 0);
    check(in_ready == 1'b0, "R7", "ready after reset", int'(in_ready), 0);
    check(bit_strobe == 1'b0, "R8", "strobe after reset", int'(bit_strobe), 0);

    // full sweep of framing options: R1 R2 R3 R4 R5
    for (int k = 0; k < 256; k++) begin
      cfg_start_bit    = k[0];
      cfg_msb_first    = k[1];
      cfg_par_en       = k[2];
      cfg_par_odd      = k[3];
      cfg_par_inv_last = k[4];
      cfg_stop         = 3'(k >> 5);
      fb[0] = 8'(k * 29 + 3);
      fb[1] = 8'(k * 71 + 156);
      run_frame(2, 1'b0, 1'b0, "R1 R2 R3 R4 R5");
    end

    // R7: in_last ends the transfer early; inversion lands on that byte (R4)
    cfg_start_bit = 1; cfg_msb_first = 0; cfg_par_en = 1; cfg_par_odd = 0;
    cfg_par_inv_last = 1; cfg_stop = 3'd3;
    for (int i = 0; i < 8; i++) fb[i] = 8'(i * 37 + 5);
    fl[2] = 1'b1;
    run_frame(5, 1'b0, 1'b0, "R7 R4");
    fl[2] = 1'b0; fl[4] = 1'b1;
    run_frame(3, 1'b0, 1'b0, "R7");
    fl[4] = 1'b0;

    // R9: stalled input leaves idle-high gaps
    cfg_stop = 3'd1;
    run_frame(4, 1'b1, 1'b0, "R9");

    // R10: mid-transfer start and configuration changes are ignored
    cfg_stop = 3'd2; cfg_msb_first = 1; cfg_par_odd = 1;
    run_frame(3, 1'b0, 1'b1, "R10");

    // R6: zero-count start
    @(negedge clk);
    cap.delete(); idle_bad = 0; byte_count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err_no_data == 1'b1, "R6", "error after zero-count start", int'(err_no_data), 1);
    check(busy == 1'b0, "R6", "busy after zero-count start", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(cap.size() == 0, "R6", "bits sent on zero count", cap.size(), 0);
    check(err_no_data == 1'b1, "R6", "error stays set", int'(err_no_data), 1);
    check(tx_bit == 1'b1 && idle_bad == 0, "R6", "line stays high", int'(tx_bit), 1);
    cfg_stop = 3'd1; cfg_msb_first = 0;
    run_frame(1, 1'b0, 1'b0, "R6");
    check(err_no_data == 1'b0, "R6", "error cleared by next start", int'(err_no_data), 0);

    summary();
  end
endmodule